// File: doc/BRIEF.md
# Banked MSI Capture and Interrupt Aggregator

This block takes inbound message-signalled interrupt writes, each given as a single-cycle strobe with a 64-bit address and a 32-bit data word. It records them in eight independent banks of 32 vectors, which gives 256 vectors in total. Each bank has its own programmable 64-bit capture address. A write that hits an enabled bank's address sets one pending bit in that bank's status, and the low five data bits select the bit. Each bank has a per-vector mask. A bank with at least one pending, unmasked vector raises its bit in a second-level summary register. The summary bits are gated by a summary enable register and combined into one registered interrupt line.

Software reaches every register through a 32-bit register write port with a 12-bit byte offset and a combinational read port. The service flow runs in this order:

1. Read the summary.
2. Walk the pending vectors of the flagged bank and clear them by writing 1s to the bank status.
3. Write 1 to the summary bit.

A vector that arrives during service keeps the bank flagged, so no event is lost.

Top module: `msi_bank_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register map, byte offsets on `reg_addr_i`:
  - Bank n (n = 0..7) has its capture address low word at 0xC00+16n, its status at 0xC04+16n and its vector mask at 0xC08+16n.
  - The capture address high word of bank n is at 0xC80+4n.
  - Capture enables are at 0x190, bits 0..7.
  - Summary enables are at 0x180, bits 8..15.
  - Summary status is at 0x184, bits 8..15, with bank n on bit 8+n.
  - Unused bits and unmapped offsets read zero.
- R3: A strobe on `msi_valid_i` sets the status bit given by `msi_data_i[4:0]` of every bank whose capture enable is 1 and whose 64-bit capture address equals `msi_addr_i`. Data bits 31..5 are ignored. The bit is visible on read one cycle after the strobe.
- R4: A strobe to a bank whose capture enable is 0, or to an address that matches no bank, changes no status bit.
- R5: Writing to a bank status register clears each bit written as 1. Bits written as 0 keep their value.
- R6: If a capture and a clear hit the same status bit in the same cycle, the bit stays set.
- R7: Summary bit 8+n becomes 1 one cycle after bank n has a status bit whose mask bit is also 1. Status bits whose mask bit is 0 do not raise the summary.
- R8: A summary bit stays set until a write of 1 to it at 0x184 in a cycle where its bank has no pending unmasked vector. A write of 1 while the bank is still pending leaves the bit set.
- R9: `irq_o` is the OR of (summary AND summary enable), delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_valid_i | input | 1 | Inbound message write strobe |
| msi_addr_i | input | 64 | Inbound message address |
| msi_data_i | input | 32 | Inbound message data; bits 4..0 select the vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Aggregated interrupt, active high |

## Verification
The assertions check these rules on every cycle and for every bank:

- A pending unmasked bank raises its summary bit on the next cycle.
- A summary bit survives unless it is cleared while its bank is idle.
- A bank with capture disabled never gains a status bit.
- The interrupt line follows the gated summary one cycle later.

Other behaviour can only be shown by the bench's scenarios: the register map, exact address matching across all 64 bits, that the upper data bits are ignored, the write-one-to-clear masks, and the case where a capture and a clear collide on the same bit. The bench compares every read and the interrupt line against a cycle model. The model runs under directed corner cases and under mixed random traffic.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  localparam int unsigned REG_AW      = 12;
  localparam int unsigned REG_DW      = 32;
  localparam int unsigned MSI_AW      = 64;
  localparam int unsigned SUM_LSB     = 8;
  localparam int unsigned BANK_STRIDE = 16;
  localparam int unsigned HI_STRIDE   = 4;

  localparam logic [REG_AW-1:0] OFS_SUM_EN   = 12'h180;
  localparam logic [REG_AW-1:0] OFS_SUM_STAT = 12'h184;
  localparam logic [REG_AW-1:0] OFS_CAP_EN   = 12'h190;
  localparam logic [REG_AW-1:0] OFS_BANK     = 12'hC00;
  localparam logic [REG_AW-1:0] OFS_HI       = 12'hC80;

  localparam logic [REG_AW-1:0] SUB_LO   = 12'h0;
  localparam logic [REG_AW-1:0] SUB_STAT = 12'h4;
  localparam logic [REG_AW-1:0] SUB_MASK = 12'h8;

  typedef struct packed {
    logic lo;
    logic hi;
    logic stat;
    logic mask;
  } bank_wr_t;

  function automatic logic [REG_AW-1:0] bank_ofs(input int unsigned n, input logic [REG_AW-1:0] sub);
    return OFS_BANK + REG_AW'(n * BANK_STRIDE) + sub;
  endfunction

  function automatic logic [REG_AW-1:0] hi_ofs(input int unsigned n);
    return OFS_HI + REG_AW'(n * HI_STRIDE);
  endfunction
endpackage

// File: rtl/msi_bank_slice.sv
module msi_bank_slice
  import msi_bank_pkg::*;
#(
  parameter int unsigned VEC = 32,
  localparam int unsigned VW = $clog2(VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              msi_valid_i,
  input  logic [MSI_AW-1:0] msi_addr_i,
  input  logic [VW-1:0]     msi_vec_i,
  input  bank_wr_t          wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [MSI_AW-1:0] addr_o,
  output logic [VEC-1:0]    stat_o,
  output logic [VEC-1:0]    mask_o,
  output logic              pend_o
);
  logic [REG_DW-1:0] lo_q, hi_q;
  logic [VEC-1:0]    stat_q, mask_q, set_vec, clr_vec;
  logic              hit;

  assign hit = msi_valid_i && cap_en_i && (msi_addr_i == {hi_q, lo_q});

  always_comb begin
    set_vec = '0;
    set_vec[msi_vec_i] = hit;
    clr_vec = wr_i.stat ? wdata_i[VEC-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_i.lo)   lo_q   <= wdata_i;
      if (wr_i.hi)   hi_q   <= wdata_i;
      if (wr_i.mask) mask_q <= wdata_i[VEC-1:0];
      // set wins over clear so a new arrival is not lost
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign addr_o = {hi_q, lo_q};
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & mask_q);
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg #(
  parameter int unsigned NB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] pend_i,
  input  logic [NB-1:0] clr_i,
  input  logic [NB-1:0] en_i,
  output logic [NB-1:0] sum_o,
  output logic          irq_o
);
  logic [NB-1:0] sum_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= pend_i | (sum_q & ~clr_i);
      irq_q <= |(sum_q & en_i);
    end
  end

  assign sum_o = sum_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/msi_bank_ctrl.sv
module msi_bank_ctrl
  import msi_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 8,
  parameter int unsigned VEC_PER_BANK = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        msi_valid_i,
  input  logic [63:0] msi_addr_i,
  input  logic [31:0] msi_data_i,
  input  logic        reg_wr_i,
  input  logic [11:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int unsigned NB  = NUM_BANKS;
  localparam int unsigned VEC = VEC_PER_BANK;
  localparam int unsigned VW  = $clog2(VEC);

  logic [NB-1:0]             cap_en_q, sum_en_q, sum_clr, pend, sum_q;
  logic [NB-1:0][VEC-1:0]    stat_all, mask_all;
  logic [NB-1:0][MSI_AW-1:0] addr_all;
  logic [31:0]               rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_en_q <= '0;
      sum_en_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == OFS_CAP_EN) cap_en_q <= reg_wdata_i[NB-1:0];
      if (reg_addr_i == OFS_SUM_EN) sum_en_q <= reg_wdata_i[SUM_LSB +: NB];
    end
  end

  assign sum_clr = (reg_wr_i && reg_addr_i == OFS_SUM_STAT) ? reg_wdata_i[SUM_LSB +: NB] : '0;

  for (genvar n = 0; n < NB; n++) begin : g_bank
    bank_wr_t wr;
    assign wr.lo   = reg_wr_i && (reg_addr_i == bank_ofs(n, SUB_LO));
    assign wr.stat = reg_wr_i && (reg_addr_i == bank_ofs(n, SUB_STAT));
    assign wr.mask = reg_wr_i && (reg_addr_i == bank_ofs(n, SUB_MASK));
    assign wr.hi   = reg_wr_i && (reg_addr_i == hi_ofs(n));

    msi_bank_slice #(.VEC(VEC)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cap_en_i    (cap_en_q[n]),
      .msi_valid_i (msi_valid_i),
      .msi_addr_i  (msi_addr_i),
      .msi_vec_i   (msi_data_i[VW-1:0]),
      .wr_i        (wr),
      .wdata_i     (reg_wdata_i),
      .addr_o      (addr_all[n]),
      .stat_o      (stat_all[n]),
      .mask_o      (mask_all[n]),
      .pend_o      (pend[n])
    );
  end

  msi_irq_agg #(.NB(NB)) u_agg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .clr_i  (sum_clr),
    .en_i   (sum_en_q),
    .sum_o  (sum_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata = '0;
    if (reg_addr_i == OFS_SUM_EN)   rdata[SUM_LSB +: NB] = sum_en_q;
    if (reg_addr_i == OFS_SUM_STAT) rdata[SUM_LSB +: NB] = sum_q;
    if (reg_addr_i == OFS_CAP_EN)   rdata[NB-1:0]        = cap_en_q;
    for (int n = 0; n < NB; n++) begin
      if (reg_addr_i == bank_ofs(n, SUB_LO))   rdata          = addr_all[n][31:0];
      if (reg_addr_i == bank_ofs(n, SUB_STAT)) rdata[VEC-1:0] = stat_all[n];
      if (reg_addr_i == bank_ofs(n, SUB_MASK)) rdata[VEC-1:0] = mask_all[n];
      if (reg_addr_i == hi_ofs(n))             rdata          = addr_all[n][63:32];
    end
  end

  assign reg_rdata_o = rdata;
endmodule

// File: rtl/msi_bank_ctrl_chk.sv
module msi_bank_ctrl_chk #(
  parameter int unsigned NB  = 8,
  parameter int unsigned VEC = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NB-1:0]          cap_en_i,
  input logic [NB-1:0][VEC-1:0] stat_i,
  input logic [NB-1:0]          pend_i,
  input logic [NB-1:0]          sum_i,
  input logic [NB-1:0]          sum_clr_i,
  input logic [NB-1:0]          sum_en_i,
  input logic                   irq_i
);
  for (genvar n = 0; n < NB; n++) begin : g_chk
    p_disabled_no_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_en_i[n] |=> ((stat_i[n] & ~$past(stat_i[n])) == '0));

    p_summary_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[n] |=> sum_i[n]);

    p_summary_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_i[n] && !sum_clr_i[n]) |=> sum_i[n]);

    p_summary_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_clr_i[n] && !pend_i[n]) |=> !sum_i[n]);
  end

  p_irq_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sum_i & sum_en_i)) |=> irq_i);

  p_irq_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sum_i & sum_en_i)) |=> !irq_i);
endmodule

bind msi_bank_ctrl msi_bank_ctrl_chk #(.NB(NUM_BANKS), .VEC(VEC_PER_BANK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cap_en_i  (cap_en_q),
  .stat_i    (stat_all),
  .pend_i    (pend),
  .sum_i     (sum_q),
  .sum_clr_i (sum_clr),
  .sum_en_i  (sum_en_q),
  .irq_i     (irq_o)
);

// File: tb/msi_bank_ctrl_bench.sv
`timescale 1ns/1ps
module msi_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msi_v = 1'b0;
  logic [63:0] msi_a = '0;
  logic [31:0] msi_d = '0;
  logic        rw = 1'b0;
  logic [11:0] ra = '0;
  logic [31:0] rwd = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_lo[8], m_hi[8], m_stat[8], m_mask[8];
  logic [7:0]  m_ben = '0, m_ien = '0, m_sum = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  msi_bank_ctrl u_msi_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .msi_valid_i(msi_v), .msi_addr_i(msi_a),
    .msi_data_i(msi_d), .reg_wr_i(rw), .reg_addr_i(ra), .reg_wdata_i(rwd),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] o_lo(int n);   return 12'(12'hC00 + 16*n);     endfunction
  function automatic logic [11:0] o_st(int n);   return 12'(12'hC04 + 16*n);     endfunction
  function automatic logic [11:0] o_mk(int n);   return 12'(12'hC08 + 16*n);     endfunction
  function automatic logic [11:0] o_hi(int n);   return 12'(12'hC80 + 4*n);      endfunction

  function automatic logic [31:0] model_rd(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h180) r = {16'h0, m_ien, 8'h0};
    if (a == 12'h184) r = {16'h0, m_sum, 8'h0};
    if (a == 12'h190) r = {24'h0, m_ben};
    for (int n = 0; n < 8; n++) begin
      if (a == o_lo(n)) r = m_lo[n];
      if (a == o_hi(n)) r = m_hi[n];
      if (a == o_st(n)) r = m_stat[n];
      if (a == o_mk(n)) r = m_mask[n];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // one clock: model advances from the inputs held across the edge
  task automatic tick();
    logic [31:0] n_lo[8], n_hi[8], n_st[8], n_mk[8];
    logic [7:0]  n_sum, sclr;
    logic        n_irq;
    sclr = (rw && ra == 12'h184) ? rwd[15:8] : 8'h0;
    for (int n = 0; n < 8; n++) begin
      logic [31:0] setv, clr;
      setv = '0;
      if (msi_v && m_ben[n] && msi_a == {m_hi[n], m_lo[n]}) setv[msi_d[4:0]] = 1'b1;
      clr  = (rw && ra == o_st(n)) ? rwd : 32'h0;
      n_st[n]  = (m_stat[n] & ~clr) | setv;
      n_lo[n]  = (rw && ra == o_lo(n)) ? rwd : m_lo[n];
      n_hi[n]  = (rw && ra == o_hi(n)) ? rwd : m_hi[n];
      n_mk[n]  = (rw && ra == o_mk(n)) ? rwd : m_mask[n];
      n_sum[n] = (|(m_stat[n] & m_mask[n])) | (m_sum[n] & ~sclr[n]);
    end
    n_irq = |(m_sum & m_ien);
    @(posedge clk);
    for (int n = 0; n < 8; n++) begin
      m_stat[n] = n_st[n]; m_lo[n] = n_lo[n]; m_hi[n] = n_hi[n]; m_mask[n] = n_mk[n];
    end
    m_sum = n_sum;
    m_irq = n_irq;
    if (rw && ra == 12'h190) m_ben = rwd[7:0];
    if (rw && ra == 12'h180) m_ien = rwd[15:8];
    @(negedge clk);
    msi_v = 1'b0;
    rw    = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    rw = 1'b1; ra = a; rwd = d;
    tick();
  endtask

  task automatic msi(logic [63:0] a, logic [31:0] d);
    msi_v = 1'b1; msi_a = a; msi_d = d;
    tick();
  endtask

  task automatic rd(logic [11:0] a, string req);
    ra = a; #0.5;
    chk(req, rdata, model_rd(a));
  endtask

  task automatic rd_lit(logic [11:0] a, logic [31:0] exp, string req);
    ra = a; #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int n = 0; n < 8; n++) begin
      m_lo[n] = '0; m_hi[n] = '0; m_stat[n] = '0; m_mask[n] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_lit(12'h180, 0, "R1"); rd_lit(12'h184, 0, "R1"); rd_lit(12'h190, 0, "R1");
    rd_lit(o_lo(5), 0, "R1"); rd_lit(o_hi(7), 0, "R1"); rd_lit(o_st(2), 0, "R1");

    // R2: register map
    for (int n = 0; n < 8; n++) begin
      wr(o_lo(n), $urandom() & 32'hFFFF_FFF0 | 32'(n));
      wr(o_hi(n), $urandom());
    end
    wr(12'h190, 32'hFFFF_FFFF);
    rd_lit(12'h190, 32'h0000_00FF, "R2 cap_en");
    wr(12'h180, 32'hFFFF_FFFF);
    rd_lit(12'h180, 32'h0000_FF00, "R2 sum_en");
    wr(o_mk(3), 32'hFFFF_FFFF);
    rd_lit(o_mk(3), 32'hFFFF_FFFF, "R2 mask");
    rd_lit(12'h004, 0, "R2 unmapped");
    for (int n = 0; n < 8; n++) begin rd(o_lo(n), "R2 lo"); rd(o_hi(n), "R2 hi"); end

    // R3: capture, upper data bits ignored
    msi({m_hi[3], m_lo[3]}, 32'hABCD_EF1F);
    rd_lit(o_st(3), 32'h8000_0000, "R3");
    rd_lit(12'h184, 0, "R7 not yet");
    tick();
    rd_lit(12'h184, 32'h0000_0800, "R7 bank3");
    chk("R9 not yet", {31'h0, irq}, 32'h0);
    tick();
    chk("R9 irq", {31'h0, irq}, 32'h1);

    // R8: clear while pending keeps summary
    wr(12'h184, 32'h0000_0800);
    rd_lit(12'h184, 32'h0000_0800, "R8 hold");
    // R6: capture and clear of the same bit together
    msi_v = 1'b1; msi_a = {m_hi[3], m_lo[3]}; msi_d = 32'd31;
    rw = 1'b1; ra = o_st(3); rwd = 32'h8000_0000;
    tick();
    rd_lit(o_st(3), 32'h8000_0000, "R6");
    // R5: W1C, zeros keep
    msi({m_hi[3], m_lo[3]}, 32'd2);
    wr(o_st(3), 32'h0000_0004);
    rd_lit(o_st(3), 32'h8000_0000, "R5 zeros keep");
    wr(o_st(3), 32'h8000_0000);
    rd_lit(o_st(3), 0, "R5 clear");
    tick();
    wr(12'h184, 32'h0000_0800);
    rd_lit(12'h184, 0, "R8 clear");
    idle(2);
    chk("R9 low", {31'h0, irq}, 32'h0);

    // R4: disabled bank and unmatched address
    wr(12'h190, 32'h0000_00DF);
    msi({m_hi[5], m_lo[5]}, 32'd7);
    rd_lit(o_st(5), 0, "R4 disabled");
    msi({m_hi[1], m_lo[1] ^ 32'h0001_0000}, 32'd4);
    msi({m_hi[1] ^ 32'h8000_0000, m_lo[1]}, 32'd4);
    rd_lit(o_st(1), 0, "R4 unmatched");

    // R7: masked status raises nothing
    msi({m_hi[0], m_lo[0]}, 32'd9);
    rd_lit(o_st(0), 32'h0000_0200, "R3 bank0");
    idle(2);
    rd_lit(12'h184, 0, "R7 masked");
    chk("R9 masked", {31'h0, irq}, 32'h0);
    wr(o_mk(0), 32'h0000_0200);
    tick();
    rd_lit(12'h184, 32'h0000_0100, "R7 unmask");
    // R9: summary enable gates irq
    wr(12'h180, 32'h0000_FE00);
    tick();
    chk("R9 gated", {31'h0, irq}, 32'h0);

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int b, k;
      b = int'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) begin
        msi_v = 1'b1;
        msi_a = ($urandom_range(0, 4) == 0) ? {$urandom(), $urandom()} : {m_hi[b], m_lo[b]};
        msi_d = $urandom();
      end
      k = int'($urandom_range(0, 9));
      if (k < 6) begin
        rw = 1'b1;
        case (k)
          0, 1: begin ra = o_st(b); rwd = $urandom() | $urandom(); end
          2:    begin ra = 12'h184; rwd = $urandom(); end
          3:    begin ra = o_mk(b); rwd = $urandom(); end
          4:    begin ra = 12'h190; rwd = $urandom() | 32'h0000_00F0; end
          default: begin ra = 12'h180; rwd = $urandom(); end
        endcase
      end
      tick();
      chk("R9 rnd", {31'h0, irq}, {31'h0, m_irq});
      case ($urandom_range(0, 3))
        0: rd(12'h184, "R8 rnd");
        1: rd(o_mk(b), "R2 rnd");
        default: rd(o_st(int'($urandom_range(0, 7))), "R3 rnd");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule